// File: doc/BRIEF.md
# Pin Function Multiplexer with Input Qualification

This block sits between a bank of bidirectional pads and the chip's peripherals. Each pin works either as a general-purpose I/O under software control or as a peripheral's signal. In GPIO mode a direction bit and a data register decide what the pad drives. In peripheral mode the peripheral's output value and output enable go straight to the pad. Every pad input is synchronised by two flops and then passes a per-pin qualifier. The qualifier changes its output only after the input has held a new level for a set number of consecutive clocks, so short glitches never reach the logic behind it.

Software reaches the block through a simple register port with a write strobe and a combinational read. That port sets the mode, the direction, the data, the wake-enable mask and, for the pins chosen by a parameter, the qualification length. A qualified falling edge on any pin whose wake enable is set raises a one-cycle wake pulse. A power controller can use this pulse to leave a low-power state.

Top module: `gpmux_bank`

## Requirements
- R1: After reset every pin is in GPIO mode (mode register, offset 0, reads 0) and is an input (direction register, offset 1, reads 0, and pad_oe is 0). Every qualification length reads 1, and the input register reads 0.
- R2: With mode bit 0 and direction bit 1, a pin drives pad_oe=1 and pad_out equal to its bit of the data register (offset 2). With direction bit 0, pad_oe is 0.
- R3: A write to offset 3 sets the data bits given as ones, a write to offset 4 clears them, and a write to offset 5 inverts them. All other data bits keep their value, and a write to offset 2 replaces the whole data register.
- R4: With mode bit 1 a pin's pad_out and pad_oe equal periph_out and periph_oe for that pin. The data and direction registers have no effect on that pad.
- R5: For a pin with qualification length N, a level change on pad_in first shows in the qualified input N+2 clocks after the first clock edge that samples it. This covers two synchroniser flops plus N matching samples.
- R6: A pulse that lasts fewer than N sampled clocks never changes the qualified input. A pulse that lasts N or more clocks does change it.
- R7: The qualification length of pin i is written at offset 8+i in bits [2:0]. A value of 0 is stored as 1 and a value above 6 is stored as 6. Pins not selected by the QUAL_PINS parameter stay at length 1 and ignore such writes. The stored length reads back at the same offset.
- R8: wake pulses high for one clock, one clock after the qualified input of a pin with its bit set in the wake-enable register (offset 6) falls. A pin whose bit is clear never raises wake.
- R9: The input register (offset 7, read-only) and periph_in both return the qualified level of every pin, whatever the pin's mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write offset |
| wr_data | input | NPINS | Write data |
| rd_addr | input | AW | Read offset |
| rd_data | output | NPINS | Read data (combinational) |
| pad_in | input | NPINS | Raw pad inputs |
| pad_out | output | NPINS | Pad output values |
| pad_oe | output | NPINS | Pad output enables |
| periph_out | input | NPINS | Peripheral output values |
| periph_oe | input | NPINS | Peripheral output enables |
| periph_in | output | NPINS | Qualified inputs routed to peripherals |
| wake | output | 1 | One-cycle wake request |

## Verification
The qualifier is swept over every length from 1 to 6 against single pulses of 1 to 7 clocks. Pass or reject for each pair separates an off-by-one in the match count from a correct filter, and the same pulses show whether wake fires only when a qualified fall occurs. Step inputs measure the exact latency at the clamped lengths and on a pin with no qualifier, which shows whether the synchroniser depth and the clamping are right. Fixed bit patterns through the set, clear and toggle writes, together with all four peripheral output and enable combinations, show whether the pad follows software or the peripheral.

// File: rtl/gpmux_pkg.sv
package gpmux_pkg;
    localparam int REG_MODE   = 0;
    localparam int REG_DIR    = 1;
    localparam int REG_DATA   = 2;
    localparam int REG_SET    = 3;
    localparam int REG_CLR    = 4;
    localparam int REG_TOG    = 5;
    localparam int REG_WAKEEN = 6;
    localparam int REG_INPUT  = 7;
    localparam int REG_QBASE  = 8;

    localparam int QLEN_W = 3;
    typedef logic [QLEN_W-1:0] qlen_t;
    localparam qlen_t QLEN_MIN = 3'd1;
    localparam qlen_t QLEN_MAX = 3'd6;

    function automatic qlen_t clamp_qlen(input qlen_t v);
        if (v < QLEN_MIN)      return QLEN_MIN;
        else if (v > QLEN_MAX) return QLEN_MAX;
        else                   return v;
    endfunction
endpackage

// File: rtl/gpmux_regs.sv
module gpmux_regs
    import gpmux_pkg::*;
#(
    parameter int NPINS = 8,
    parameter logic [NPINS-1:0] QUAL_PINS = '1,
    parameter int AW = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [AW-1:0]           wr_addr,
    input  logic [NPINS-1:0]        wr_data,
    input  logic [AW-1:0]           rd_addr,
    output logic [NPINS-1:0]        rd_data,
    input  logic [NPINS-1:0]        qual_in,
    output logic [NPINS-1:0]        mode_o,
    output logic [NPINS-1:0]        dir_o,
    output logic [NPINS-1:0]        data_o,
    output logic [NPINS-1:0]        wake_en_o,
    output logic [NPINS-1:0][QLEN_W-1:0] qlen_o
);
    typedef struct packed {
        logic [NPINS-1:0]             mode;
        logic [NPINS-1:0]             dir;
        logic [NPINS-1:0]             data;
        logic [NPINS-1:0]             wake_en;
        logic [NPINS-1:0][QLEN_W-1:0] qlen;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (int'(wr_addr))
                REG_MODE:   st_d.mode    = wr_data;
                REG_DIR:    st_d.dir     = wr_data;
                REG_DATA:   st_d.data    = wr_data;
                REG_SET:    st_d.data    = st_q.data | wr_data;
                REG_CLR:    st_d.data    = st_q.data & ~wr_data;
                REG_TOG:    st_d.data    = st_q.data ^ wr_data;
                REG_WAKEEN: st_d.wake_en = wr_data;
                default: begin
                    for (int i = 0; i < NPINS; i++) begin
                        if (QUAL_PINS[i] && (int'(wr_addr) == REG_QBASE + i)) begin
                            st_d.qlen[i] = clamp_qlen(wr_data[QLEN_W-1:0]);
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.mode    <= '0;
            st_q.dir     <= '0;
            st_q.data    <= '0;
            st_q.wake_en <= '0;
            for (int i = 0; i < NPINS; i++) begin
                st_q.qlen[i] <= QLEN_MIN;
            end
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_data = '0;
        case (int'(rd_addr))
            REG_MODE:   rd_data = st_q.mode;
            REG_DIR:    rd_data = st_q.dir;
            REG_DATA:   rd_data = st_q.data;
            REG_WAKEEN: rd_data = st_q.wake_en;
            REG_INPUT:  rd_data = qual_in;
            default: begin
                for (int i = 0; i < NPINS; i++) begin
                    if (int'(rd_addr) == REG_QBASE + i) begin
                        rd_data = NPINS'(st_q.qlen[i]);
                    end
                end
            end
        endcase
    end

    assign mode_o    = st_q.mode;
    assign dir_o     = st_q.dir;
    assign data_o    = st_q.data;
    assign wake_en_o = st_q.wake_en;
    assign qlen_o    = st_q.qlen;

    // R3
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_en) |-> $stable(st_q.data));

    generate
        for (genvar g = 0; g < NPINS; g++) begin : g_qchk
            // R7
            qual_len_range_chk: assert property (@(posedge clk) disable iff (rst)
                (st_q.qlen[g] >= QLEN_MIN) && (st_q.qlen[g] <= QLEN_MAX)
                && (QUAL_PINS[g] || st_q.qlen[g] == QLEN_MIN));
        end
    endgenerate
endmodule

// File: rtl/gpmux_qual.sv
module gpmux_qual
    import gpmux_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pin_i,
    input  logic [QLEN_W-1:0] len_i,
    output logic              qual_o
);
    typedef struct packed {
        logic              s1;
        logic              s2;
        logic              q;
        logic [QLEN_W-1:0] cnt;
    } qst_t;

    qst_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = pin_i;
        st_d.s2 = st_q.s1;
        if (st_q.s2 == st_q.q) begin
            st_d.cnt = '0;
        end else if ((st_q.cnt + 1'b1) >= len_i) begin
            st_d.q   = st_q.s2;
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign qual_o = st_q.q;

    // R6
    qual_change_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.q != $past(st_q.q)) |-> ($past(st_q.s2) == st_q.q));

    // R5
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt < QLEN_MAX);
endmodule

// File: rtl/gpmux_bank.sv
module gpmux_bank
    import gpmux_pkg::*;
#(
    parameter int NPINS = 8,
    parameter logic [NPINS-1:0] QUAL_PINS = 8'h0F,
    localparam int AW = $clog2(REG_QBASE + NPINS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [NPINS-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [NPINS-1:0] rd_data,
    input  logic [NPINS-1:0] pad_in,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe,
    input  logic [NPINS-1:0] periph_out,
    input  logic [NPINS-1:0] periph_oe,
    output logic [NPINS-1:0] periph_in,
    output logic             wake
);
    logic [NPINS-1:0] mode, dir, data, wake_en, qual;
    logic [NPINS-1:0][QLEN_W-1:0] qlen;

    gpmux_regs #(.NPINS(NPINS), .QUAL_PINS(QUAL_PINS), .AW(AW)) regs_i (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .qual_in(qual),
        .mode_o(mode), .dir_o(dir), .data_o(data),
        .wake_en_o(wake_en), .qlen_o(qlen)
    );

    generate
        for (genvar g = 0; g < NPINS; g++) begin : g_pin
            gpmux_qual qual_i (
                .clk(clk), .rst(rst),
                .pin_i(pad_in[g]), .len_i(qlen[g]),
                .qual_o(qual[g])
            );
        end
    endgenerate

    always_comb begin
        for (int i = 0; i < NPINS; i++) begin
            if (mode[i]) begin
                pad_out[i] = periph_out[i];
                pad_oe[i]  = periph_oe[i];
            end else begin
                pad_out[i] = data[i];
                pad_oe[i]  = dir[i];
            end
        end
    end

    assign periph_in = qual;

    typedef struct packed {
        logic [NPINS-1:0] prev;
        logic             wake;
    } wst_t;

    wst_t w_d, w_q;

    always_comb begin
        w_d.prev = qual;
        w_d.wake = |(w_q.prev & ~qual & wake_en);
    end

    always_ff @(posedge clk) begin
        if (rst) w_q <= '0;
        else     w_q <= w_d;
    end

    assign wake = w_q.wake;

    // R8
    wake_src_chk: assert property (@(posedge clk) disable iff (rst)
        wake |-> $past(|(wake_en & ~qual)));

    // R8
    wake_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        wake |=> !wake || $past(|(wake_en & ~qual)));
endmodule

// File: tb/gpmux_bank_tb.sv
module gpmux_bank_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NPINS = 8;
    localparam int AW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [NPINS-1:0] wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [NPINS-1:0] rd_data;
    logic [NPINS-1:0] pad_in = '0;
    logic [NPINS-1:0] pad_out, pad_oe;
    logic [NPINS-1:0] periph_out = '0;
    logic [NPINS-1:0] periph_oe = '0;
    logic [NPINS-1:0] periph_in;
    logic wake;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    gpmux_bank #(.NPINS(NPINS), .QUAL_PINS(8'h0F)) dut_i (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .periph_out(periph_out), .periph_oe(periph_oe),
        .periph_in(periph_in), .wake(wake)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s got=%0d exp=%0d", req, got, exp);
        end
    endtask

    task automatic wr(input int a, input logic [NPINS-1:0] d);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [NPINS-1:0] d);
        rd_addr = AW'(a);
        #1;
        d = rd_data;
    endtask

    // step pin to lvl and count samples until the input register shows it
    task automatic latency(input int pin, input logic lvl, output int c);
        c = 0;
        rd_addr = AW'(7);
        pad_in[pin] = lvl;
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            if (c == 0 && rd_data[pin] == lvl) c = k;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [NPINS-1:0] v;
        int c;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(0, v); chk("R1 mode", int'(v), 0);
        rd(1, v); chk("R1 dir", int'(v), 0);
        chk("R1 pad_oe", int'(pad_oe), 0);
        rd(7, v); chk("R1 input", int'(v), 0);
        rd(8, v); chk("R1 qlen", int'(v), 1);

        // R2 / R3 GPIO output and strobes
        wr(1, 8'hFF);
        wr(2, 8'hA5);
        chk("R2 pad_oe", int'(pad_oe), 8'hFF);
        chk("R2 pad_out", int'(pad_out), 8'hA5);
        wr(3, 8'h0A); rd(2, v); chk("R3 set", int'(v), 8'hAF);
        wr(4, 8'h21); rd(2, v); chk("R3 clr", int'(v), 8'h8E);
        wr(5, 8'hFF); rd(2, v); chk("R3 tog", int'(v), 8'h71);
        chk("R3 pad_out", int'(pad_out), 8'h71);
        wr(1, 8'h0F);
        chk("R2 dir off", int'(pad_oe), 8'h0F);

        // R4 peripheral mode, all out/oe combinations on pin 6
        wr(0, 8'h40);
        for (int m = 0; m < 4; m++) begin
            periph_out = {1'b0, m[0], 6'b0};
            periph_oe  = {1'b0, m[1], 6'b0};
            wr(2, m[0] ? 8'h00 : 8'hFF);
            wr(1, m[1] ? 8'h00 : 8'hFF);
            chk("R4 out", int'(pad_out[6]), int'(m[0]));
            chk("R4 oe", int'(pad_oe[6]), int'(m[1]));
        end

        // R9 qualified input visible in peripheral mode
        latency(6, 1'b1, c);
        chk("R9 input reg", int'(rd_data[6]), 1);
        chk("R9 periph_in", int'(periph_in[6]), 1);
        latency(6, 1'b0, c);
        wr(0, 8'h00);

        // R7 clamping and readback, R5 latency at clamped lengths
        wr(8, 8'h00); rd(8, v); chk("R7 clamp lo", int'(v), 1);
        latency(0, 1'b1, c); chk("R5 lat N1", c, 3);
        latency(0, 1'b0, c);
        wr(8, 8'h07); rd(8, v); chk("R7 clamp hi", int'(v), 6);
        latency(0, 1'b1, c); chk("R5 lat N6", c, 8);
        latency(0, 1'b0, c);
        wr(13, 8'h06); rd(13, v); chk("R7 nonqual", int'(v), 1);
        latency(5, 1'b1, c); chk("R7 nonqual lat", c, 3);
        latency(5, 1'b0, c);

        // R6 / R8 sweep: length N vs pulse P on pin 0, wake enabled
        wr(6, 8'h01);
        for (int n = 1; n <= 6; n++) begin
            wr(8, NPINS'(n));
            for (int p = 1; p <= 7; p++) begin
                int seen;
                int wakes;
                seen = 0; wakes = 0;
                rd_addr = AW'(7);
                pad_in[0] = 1'b1;
                for (int k = 1; k <= p + 16; k++) begin
                    @(negedge clk);
                    if (k == p) pad_in[0] = 1'b0;
                    if (rd_data[0]) seen = 1;
                    if (wake) wakes++;
                end
                chk("R6 glitch filter", seen, (p >= n) ? 1 : 0);
                chk("R8 wake count", wakes, (p >= n) ? 1 : 0);
            end
        end

        // R8 disabled pin never wakes
        begin
            int wakes;
            wakes = 0;
            wr(6, 8'h00);
            pad_in[1] = 1'b1;
            repeat (6) @(negedge clk);
            pad_in[1] = 1'b0;
            for (int k = 0; k < 10; k++) begin
                @(negedge clk);
                if (wake) wakes++;
            end
            chk("R8 masked", wakes, 0);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule